// File: doc/BRIEF.md
# Output Rail Sequencer and Fault Supervisor

This block supervises one output rail of a step-down regulator. It decides when the rail may regulate, waits out the programmed turn-on and turn-off delays, and reports when the output is good. It also reacts to over-voltage, under-voltage, over-current and over-temperature conditions. The analog loop, the soft-start ramp generator and the measurement converters are outside the block. The block receives their results as single-bit flags, plus one temperature reading, and it returns a single regulate request to them.

Each fault source is configured on its own to either latch the rail off or retry after a programmable wait. Every source sets a sticky status bit, and that bit feeds a shared alert request through a per-source mask. All delays are counted in a coarse time base. One tick lasts `TICK_DIV` core clocks.

Top module: `rail_seq_ctrl`

## Requirements
- R1: The rail is enabled only when `en_pin` differs from `en_active_low` and `op_on` is high. If either condition is missing, the rail does not start, and a rail that is running begins its shutdown.
- R2: When the rail starts from off, `run_req` rises at the rising edge numbered `ton_dly*TICK_DIV+2`, where edge 1 is the first edge that sees the effective enable high.
- R3: When the effective enable drops during regulation, `run_req` falls at edge `toff_dly*TICK_DIV+2`, where edge 1 is the first edge that sees the enable low.
- R4: A `ramp_done` pulse moves the rail into regulation. `pgood` rises at edge `PG_ON_CYC+1` after the pulse is seen, provided `vout_in_band` stays high and no fault is present.
- R5: `pgood` falls only after the good condition has been absent for `PG_OFF_CYC` consecutive edges. A shorter loss of band leaves `pgood` high.
- R6: While the rail runs (`run_req` high), a fault from any source whose `resp_hiccup` bit is 0 clears `run_req` at the next edge and latches the rail off. `clr_faults` or a disable releases the latch. A new start needs the effective enable to be seen low first.
- R7: If every active fault source has its `resp_hiccup` bit set, `run_req` drops at the next edge. After `retry_dly*TICK_DIV+1` cycles with no fault active, the turn-on delay runs again and the rail restarts.
- R8: The over-temperature condition becomes active when `temp_c >= ot_limit`. It becomes inactive only when `temp_c + ot_hyst <= ot_limit`. A retry stays blocked while the condition is active.
- R9: The `status` bits are sticky: bit 0 is over-voltage, bit 1 under-voltage, bit 2 over-current and bit 3 over-temperature. A bit stays set after its condition goes away until `clr_faults` is applied. A clear has no effect on a condition that is still present.
- R10: `alert_req` is high exactly when some set status bit has its `alert_mask` bit at 0. A mask bit of 1 still lets the status bit set.
- R11: During reset and right after it, `run_req`, `pgood`, `status` and `alert_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_pin | input | 1 | Enable pin level |
| en_active_low | input | 1 | 1 makes a low `en_pin` the enabling level |
| op_on | input | 1 | On/off command, 1 allows the rail to run |
| ramp_done | input | 1 | Soft-start ramp has reached its target |
| vout_in_band | input | 1 | Output voltage lies inside the good window |
| flt_ov | input | 1 | Output over-voltage comparator |
| flt_uv | input | 1 | Output under-voltage comparator |
| flt_oc | input | 1 | Over-current comparator |
| temp_c | input | TEMP_W | Power train temperature in degrees |
| ot_limit | input | TEMP_W | Over-temperature trip level |
| ot_hyst | input | TEMP_W | Fall required before the trip clears |
| resp_hiccup | input | 4 | Per-source response, 1 = retry, 0 = latch off |
| alert_mask | input | 4 | Per-source alert deselect, 1 = suppressed |
| clr_faults | input | 1 | Clears sticky status and releases a latch |
| ton_dly | input | DLY_W | Turn-on delay in ticks |
| toff_dly | input | DLY_W | Turn-off delay in ticks |
| retry_dly | input | DLY_W | Hiccup wait in ticks |
| run_req | output | 1 | Regulate / soft-start request |
| pgood | output | 1 | Power-good indication |
| status | output | 4 | Sticky fault status |
| alert_req | output | 1 | Alert request toward the bus interface |

## Verification
The turn-on and turn-off delays are swept together over sixteen combinations. Each combination exposes both edge counts, so an off-by-one in the tick prescaler separates from one in the state machine. Each of the three comparator faults is applied once with the latch response and once with the retry response. These cases separate an immediate restart, a restart after the retry wait, and a latch that needs an enable toggle. Every alert mask is then swept against every source while the rail is off, which isolates masking from sequencing. The temperature is stepped below the trip level, at it, inside the hysteresis band and at the release level, to locate both thresholds.

// File: rtl/rail_seq_pkg.sv
// Shared types for the rail sequencer.
// Assumes: four fault sources, with bit positions fixed as listed below.
package rail_seq_pkg;
    localparam int NFLT   = 4;
    localparam int FLT_OV = 0;
    localparam int FLT_UV = 1;
    localparam int FLT_OC = 2;
    localparam int FLT_OT = 3;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ON_WAIT,
        ST_RAMP,
        ST_REG,
        ST_OFF_WAIT,
        ST_LATCHED,
        ST_RETRY
    } rail_state_t;
endpackage

// File: rtl/rail_delay_timer.sv
// Tick-based down counter shared by every timed state.
// A load restarts the prescaler, so an interval lasts exactly
// load_val*TICK_DIV cycles.
// Assumes: TICK_DIV >= 1.
module rail_delay_timer #(
    parameter int TICK_DIV = 1000,
    parameter int DLY_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             expired
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [DLY_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;

    // Load, then count ticks down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
            pre_q <= '0;
        end else if (cnt_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rail_pgood_filter.sv
// Power-good filter with separate qualify times for assert and deassert.
// Assumes: ON_CYC >= 1 and OFF_CYC >= 1.
module rail_pgood_filter #(
    parameter int ON_CYC  = 42,
    parameter int OFF_CYC = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic good_in,
    output logic pgood
);
    localparam int MAXC = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYC - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYC - 1);

    logic          pg_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    assign last = pg_q ? OFF_LAST : ON_LAST;

    // Count consecutive disagreeing cycles, and flip once the run is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q  <= 1'b0;
            cnt_q <= '0;
        end else if (good_in != pg_q) begin
            if (cnt_q == last) begin
                pg_q  <= good_in;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign pgood = pg_q;
endmodule

// File: rtl/rail_fault_track.sv
// Fault source collection: over-temperature hysteresis, sticky status
// bits and the masked alert request.
// Assumes: comparator flags are already synchronous to clk.
module rail_fault_track
    import rail_seq_pkg::*;
#(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_ov,
    input  logic              flt_uv,
    input  logic              flt_oc,
    input  logic [TEMP_W-1:0] temp_c,
    input  logic [TEMP_W-1:0] ot_limit,
    input  logic [TEMP_W-1:0] ot_hyst,
    input  logic              clr_faults,
    input  logic [NFLT-1:0]   alert_mask,
    output logic [NFLT-1:0]   fault_now,
    output logic [NFLT-1:0]   status,
    output logic              alert_req
);
    logic            ot_hot_q;
    logic [TEMP_W:0] temp_plus_hyst;

    assign temp_plus_hyst = {1'b0, temp_c} + {1'b0, ot_hyst};

    // Over-temperature trips at the limit and releases one hysteresis below it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ot_hot_q <= 1'b0;
        else if (temp_c >= ot_limit)
            ot_hot_q <= 1'b1;
        else if (temp_plus_hyst <= {1'b0, ot_limit})
            ot_hot_q <= 1'b0;
    end

    always_comb begin
        fault_now         = '0;
        fault_now[FLT_OV] = flt_ov;
        fault_now[FLT_UV] = flt_uv;
        fault_now[FLT_OC] = flt_oc;
        fault_now[FLT_OT] = ot_hot_q;
    end

    for (genvar i = 0; i < NFLT; i++) begin : g_stat
        // Sticky bit: a present condition wins over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[i] <= 1'b0;
            else if (fault_now[i])
                status[i] <= 1'b1;
            else if (clr_faults)
                status[i] <= 1'b0;
        end
    end

    assign alert_req = |(status & ~alert_mask);
endmodule

// File: rtl/rail_seq_ctrl.sv
// Rail supervisory state machine.
// It sequences turn-on, ramp, regulation and turn-off, and it dispatches
// each fault to a latch-off or retry response per source.
// Assumes: all inputs are synchronous to clk. Delays are in ticks of TICK_DIV clocks.
module rail_seq_ctrl
    import rail_seq_pkg::*;
#(
    parameter int TICK_DIV   = 1000,
    parameter int DLY_W      = 9,
    parameter int PG_ON_CYC  = 42,
    parameter int PG_OFF_CYC = 31,
    parameter int TEMP_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_pin,
    input  logic              en_active_low,
    input  logic              op_on,
    input  logic              ramp_done,
    input  logic              vout_in_band,
    input  logic              flt_ov,
    input  logic              flt_uv,
    input  logic              flt_oc,
    input  logic [TEMP_W-1:0] temp_c,
    input  logic [TEMP_W-1:0] ot_limit,
    input  logic [TEMP_W-1:0] ot_hyst,
    input  logic [3:0]        resp_hiccup,
    input  logic [3:0]        alert_mask,
    input  logic              clr_faults,
    input  logic [DLY_W-1:0]  ton_dly,
    input  logic [DLY_W-1:0]  toff_dly,
    input  logic [DLY_W-1:0]  retry_dly,
    output logic              run_req,
    output logic              pgood,
    output logic [3:0]        status,
    output logic              alert_req
);
    rail_state_t      st_q, st_d;
    logic             en_eff, armed_q, any_flt, latch_hit;
    logic             tmr_load, tmr_done, good_now;
    logic [DLY_W-1:0] tmr_val;
    logic [NFLT-1:0]  fault_now;

    assign en_eff    = (en_pin ^ en_active_low) & op_on;
    assign any_flt   = |fault_now;
    assign latch_hit = |(fault_now & ~resp_hiccup);

    rail_fault_track #(.TEMP_W(TEMP_W)) u_flt (
        .clk(clk), .rst_n(rst_n),
        .flt_ov(flt_ov), .flt_uv(flt_uv), .flt_oc(flt_oc),
        .temp_c(temp_c), .ot_limit(ot_limit), .ot_hyst(ot_hyst),
        .clr_faults(clr_faults), .alert_mask(alert_mask),
        .fault_now(fault_now), .status(status), .alert_req(alert_req)
    );

    rail_delay_timer #(.TICK_DIV(TICK_DIV), .DLY_W(DLY_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .expired(tmr_done)
    );

    // Next-state selection. Faults while running take priority over enable changes.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_OFF:
                if (en_eff && armed_q && !any_flt) st_d = ST_ON_WAIT;
            ST_ON_WAIT:
                if (!en_eff)       st_d = ST_OFF;
                else if (tmr_done) st_d = ST_RAMP;
            ST_RAMP, ST_REG, ST_OFF_WAIT:
                if (any_flt) begin
                    st_d = latch_hit ? ST_LATCHED : ST_RETRY;
                end else if (st_q == ST_OFF_WAIT) begin
                    if (en_eff)        st_d = ST_REG;
                    else if (tmr_done) st_d = ST_OFF;
                end else if (!en_eff) begin
                    st_d = ST_OFF_WAIT;
                end else if (st_q == ST_RAMP && ramp_done) begin
                    st_d = ST_REG;
                end
            ST_LATCHED:
                if (clr_faults || !en_eff) st_d = ST_OFF;
            ST_RETRY:
                if (!en_eff)                   st_d = ST_OFF;
                else if (tmr_done && !any_flt) st_d = ST_ON_WAIT;
            default:
                st_d = ST_OFF;
        endcase
    end

    // Choose the interval to load when entering a timed state.
    always_comb begin
        tmr_load = (st_d != st_q) &&
                   (st_d == ST_ON_WAIT || st_d == ST_OFF_WAIT || st_d == ST_RETRY);
        case (st_d)
            ST_ON_WAIT:  tmr_val = ton_dly;
            ST_OFF_WAIT: tmr_val = toff_dly;
            ST_RETRY:    tmr_val = retry_dly;
            default:     tmr_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // Restart permission: disarmed by a latch-off and re-armed by a seen disable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b1;
        else if (!en_eff)
            armed_q <= 1'b1;
        else if (st_d == ST_LATCHED && st_q != ST_LATCHED)
            armed_q <= 1'b0;
    end

    assign run_req  = (st_q == ST_RAMP) || (st_q == ST_REG) || (st_q == ST_OFF_WAIT);
    assign good_now = (st_q == ST_REG) && vout_in_band && !any_flt;

    rail_pgood_filter #(.ON_CYC(PG_ON_CYC), .OFF_CYC(PG_OFF_CYC)) u_pg (
        .clk(clk), .rst_n(rst_n), .good_in(good_now), .pgood(pgood)
    );
endmodule

// File: rtl/rail_seq_chk.sv
// Port-level temporal checks for rail_seq_ctrl, attached with a bind.
// Assumes: the same clock and synchronous reset as the checked block.
module rail_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_pin,
    input logic       en_active_low,
    input logic       op_on,
    input logic       vout_in_band,
    input logic       flt_ov,
    input logic       flt_uv,
    input logic       flt_oc,
    input logic [3:0] resp_hiccup,
    input logic       clr_faults,
    input logic       run_req,
    input logic       pgood,
    input logic [3:0] status,
    input logic       alert_req
);
    // R1
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_req) |-> $past((en_pin ^ en_active_low) && op_on));

    // R4
    pg_rise_in_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> (run_req && $past(vout_in_band)));

    // R6
    latch_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && (|({flt_oc, flt_uv, flt_ov} & ~resp_hiccup[2:0]))) |=> !run_req);

    // R7
    any_fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_req && (flt_ov || flt_uv || flt_oc)) |=> !run_req);

    // R9
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(status) & ~status)) |-> $past(clr_faults));

    // R10
    alert_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alert_req |-> (|status));
endmodule

bind rail_seq_ctrl rail_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_active_low(en_active_low),
    .op_on(op_on), .vout_in_band(vout_in_band), .flt_ov(flt_ov), .flt_uv(flt_uv),
    .flt_oc(flt_oc), .resp_hiccup(resp_hiccup), .clr_faults(clr_faults),
    .run_req(run_req), .pgood(pgood), .status(status), .alert_req(alert_req)
);

// File: tb/tb_rail_seq_ctrl.sv
module tb_rail_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TD = 4;
    localparam int DW = 4;
    localparam int PON = 6;
    localparam int POFF = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin = 1'b0, en_active_low = 1'b0, op_on = 1'b1;
    logic ramp_done = 1'b0, vout_in_band = 1'b1;
    logic flt_ov = 1'b0, flt_uv = 1'b0, flt_oc = 1'b0, clr_faults = 1'b0;
    logic [7:0] temp_c = 8'd25, ot_limit = 8'd120, ot_hyst = 8'd18;
    logic [3:0] resp_hiccup = 4'h0, alert_mask = 4'h0;
    logic [DW-1:0] ton_dly = '0, toff_dly = '0, retry_dly = '0;
    logic run_req, pgood, alert_req;
    logic [3:0] status;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_seq_ctrl #(.TICK_DIV(TD), .DLY_W(DW), .PG_ON_CYC(PON), .PG_OFF_CYC(POFF),
                    .TEMP_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .en_active_low(en_active_low),
        .op_on(op_on), .ramp_done(ramp_done), .vout_in_band(vout_in_band),
        .flt_ov(flt_ov), .flt_uv(flt_uv), .flt_oc(flt_oc), .temp_c(temp_c),
        .ot_limit(ot_limit), .ot_hyst(ot_hyst), .resp_hiccup(resp_hiccup),
        .alert_mask(alert_mask), .clr_faults(clr_faults), .ton_dly(ton_dly),
        .toff_dly(toff_dly), .retry_dly(retry_dly), .run_req(run_req),
        .pgood(pgood), .status(status), .alert_req(alert_req)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic sig(input int which);
        return (which == 0) ? run_req : pgood;
    endfunction

    // Count edges until the chosen output reaches lvl.
    task automatic wait_for(input int which, input logic lvl, input int start, output int k);
        k = start;
        while (sig(which) != lvl && k < 200) begin
            cyc(1);
            k++;
        end
    endtask

    // Bring the rail into regulation with pgood high.
    task automatic bring_up();
        int k;
        en_pin = 1'b0;
        cyc(4);
        ton_dly = '0;
        en_pin = 1'b1;
        wait_for(0, 1'b1, 0, k);
        ramp_done = 1'b1;
        cyc(1);
        ramp_done = 1'b0;
        cyc(PON + 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k, kpg, krun;
        @(negedge clk);
        cyc(3);
        // R11 reset state
        check_eq("R11 run_req in reset", run_req, 0);
        check_eq("R11 pgood in reset", pgood, 0);
        check_eq("R11 status in reset", status, 0);
        rst_n = 1'b1;
        cyc(2);
        check_eq("R11 alert after reset", alert_req, 0);
        check_eq("R11 run_req after reset", run_req, 0);

        // R2 R3 R4 R5: sweep turn-on and turn-off delays
        for (int n = 0; n < 4; n++) begin
            for (int t = 0; t < 4; t++) begin
                ton_dly = DW'(n);
                toff_dly = DW'(t);
                en_pin = 1'b1;
                wait_for(0, 1'b1, 0, k);
                check_eq("R2 turn-on edge", k, n*TD + 2);
                ramp_done = 1'b1;
                cyc(1);
                ramp_done = 1'b0;
                wait_for(1, 1'b1, 1, k);
                check_eq("R4 pgood assert edge", k, PON + 1);
                en_pin = 1'b0;
                kpg = 0; krun = 0;
                for (int e = 1; e <= 40; e++) begin
                    cyc(1);
                    if (!pgood && kpg == 0) kpg = e;
                    if (!run_req && krun == 0) krun = e;
                end
                check_eq("R3 turn-off edge", krun, t*TD + 2);
                check_eq("R5 pgood drop after disable", kpg, POFF + 1);
            end
        end

        // R1 polarity and on/off command gating
        ton_dly = '0; toff_dly = '0;
        en_pin = 1'b1; op_on = 1'b0;
        cyc(10);
        check_eq("R1 op_on low blocks start", run_req, 0);
        en_active_low = 1'b1; op_on = 1'b1;
        cyc(10);
        check_eq("R1 high pin is inactive when active-low", run_req, 0);
        en_pin = 1'b0;
        wait_for(0, 1'b1, 0, k);
        check_eq("R1 low pin enables when active-low", k, 2);
        op_on = 1'b0;
        wait_for(0, 1'b0, 0, k);
        check_eq("R1 op_on off stops rail", k, 2);
        op_on = 1'b1;
        wait_for(0, 1'b1, 0, k);
        check_eq("R1 op_on on restarts rail", k, 2);
        en_pin = 1'b1;
        wait_for(0, 1'b0, 0, k);
        check_eq("R1 inactive pin level stops rail", k, 2);
        en_active_low = 1'b0; en_pin = 1'b0;
        cyc(3);

        // R5 short loss of band keeps pgood, long loss drops it
        bring_up();
        check_eq("R4 pgood high in regulation", pgood, 1);
        vout_in_band = 1'b0;
        cyc(POFF - 1);
        vout_in_band = 1'b1;
        cyc(1);
        check_eq("R5 short band loss ignored", pgood, 1);
        cyc(2);
        vout_in_band = 1'b0;
        wait_for(1, 1'b0, 0, k);
        check_eq("R5 pgood deassert edge", k, POFF);
        vout_in_band = 1'b1;
        wait_for(1, 1'b1, 0, k);
        check_eq("R4 pgood reassert edge", k, PON);

        // R6 R7 R9 R10: each comparator fault, latch and retry responses
        for (int f = 0; f < 3; f++) begin
            for (int h = 0; h < 2; h++) begin
                toff_dly = '0;
                bring_up();
                resp_hiccup = h ? 4'b0111 : 4'b0000;
                retry_dly = DW'(1);
                ton_dly = DW'(1);
                if (f == 0) flt_ov = 1'b1;
                if (f == 1) flt_uv = 1'b1;
                if (f == 2) flt_oc = 1'b1;
                cyc(1);
                flt_ov = 1'b0; flt_uv = 1'b0; flt_oc = 1'b0;
                check_eq(h ? "R7 fault stops rail" : "R6 fault stops rail", run_req, 0);
                check_eq("R9 status bit set", status, 1 << f);
                check_eq("R10 unmasked alert", alert_req, 1);
                if (h == 1) begin
                    wait_for(0, 1'b1, 1, k);
                    check_eq("R7 hiccup restart edge", k, TD + TD + 3);
                    check_eq("R9 status sticky after restart", status, 1 << f);
                    clr_faults = 1'b1;
                    cyc(1);
                    clr_faults = 1'b0;
                end else begin
                    cyc(30);
                    check_eq("R6 latched off", run_req, 0);
                    clr_faults = 1'b1;
                    cyc(1);
                    clr_faults = 1'b0;
                    check_eq("R9 clear empties status", status, 0);
                    cyc(10);
                    check_eq("R6 clear without toggle stays off", run_req, 0);
                    en_pin = 1'b0;
                    cyc(2);
                    en_pin = 1'b1;
                    wait_for(0, 1'b1, 0, k);
                    check_eq("R6 restart after toggle", k, TD + 2);
                end
            end
        end
        resp_hiccup = 4'h0;
        en_pin = 1'b0;
        cyc(4);

        // R10 R9: every mask against every source while off
        for (int m = 0; m < 16; m++) begin
            for (int f = 0; f < 4; f++) begin
                alert_mask = 4'(m);
                if (f == 0) flt_ov = 1'b1;
                if (f == 1) flt_uv = 1'b1;
                if (f == 2) flt_oc = 1'b1;
                if (f == 3) temp_c = 8'd130;
                cyc(1);
                flt_ov = 1'b0; flt_uv = 1'b0; flt_oc = 1'b0; temp_c = 8'd25;
                cyc(1);
                check_eq("R9 only source bit set", status, 1 << f);
                check_eq("R10 alert follows mask", alert_req, ((m >> f) & 1) ? 0 : 1);
                clr_faults = 1'b1;
                cyc(1);
                clr_faults = 1'b0;
                check_eq("R9 cleared when gone", status, 0);
            end
        end
        alert_mask = 4'h0;

        // R8 over-temperature hysteresis with retry response
        resp_hiccup = 4'b1000; retry_dly = '0;
        bring_up();
        temp_c = 8'd119;
        cyc(10);
        check_eq("R8 below limit keeps running", run_req, 1);
        temp_c = 8'd120;
        wait_for(0, 1'b0, 0, k);
        check_eq("R8 trip at limit edge", k, 2);
        clr_faults = 1'b1;
        cyc(1);
        clr_faults = 1'b0;
        check_eq("R9 clear ignored while hot", status, 8);
        temp_c = 8'd110;
        cyc(20);
        check_eq("R8 inside hysteresis blocks retry", run_req, 0);
        temp_c = 8'd102;
        wait_for(0, 1'b1, 0, k);
        check_eq("R8 release level restart edge", k, 3);
        temp_c = 8'd25;
        clr_faults = 1'b1;
        cyc(1);
        clr_faults = 1'b0;
        check_eq("R9 cleared after cool", status, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule